// File: doc/BRIEF.md
# Scan Sync Guard

This block lives in each column-driver tile of a cascaded display and keeps the tiles' scan timing in step. A tile in follower mode compares its own pair of row-select levels against the pair received from the lead tile. The comparison happens once per half-frame, on the rising edge of the frame pulse. If the pairs differ, the tile pulls a shared active-low refresh line for a fixed number of cycles.

The refresh line is open-drain and shared by every tile. Any tile that senses it low, whichever tile drove it, raises an internal reset that re-initialises its timing. That reset is held for one cycle beyond the sensed low period. After it is released, the tile keeps its display blanked for four further frames, so that a garbled picture is never shown while the tiles settle. A tile in lead mode never compares and never pulls the line, but it still obeys it.

The same blanking hold follows the block's own power-on reset. The comparison stays disarmed for the first half-frame after any reset, and also after a switch into follower mode, so that start-up skew cannot start a refresh storm.

Top module: `scan_sync_guard`

## Requirements
- R1: After `rst_ni` is released, `refresh_pull_o` and `tile_reset_o` are 0 and `display_blank_o` is 1.
- R2: In follower mode (`slave_mode_i`=1) the pairs are compared in the clock cycle in which `frame_i` is first seen high after being low. If any bit differs, `refresh_pull_o` goes to 1 on the next clock edge.
- R3: The first frame rising edge after any reset is not compared; it only arms the comparison. This covers `rst_ni`, the tile reset, and any cycle with `slave_mode_i`=0.
- R4: Once raised, `refresh_pull_o` stays at 1 for exactly DRIVE_CYCLES (default 4) clock cycles and then returns to 0.
- R5: `refresh_line_ni` passes through a two-flop synchroniser. A low level on it makes `tile_reset_o` go to 1 two clock edges later, whether or not this tile drove the line.
- R6: `tile_reset_o` stays at 1 for the sensed low duration plus one clock cycle. A line held low for N cycles gives N+1 cycles of reset.
- R7: `display_blank_o` is 1 while `tile_reset_o` is 1. It stays at 1 after the tile reset (or after `rst_ni`) until BLANK_FRAMES×EDGES_PER_FRAME (default 8) further frame rising edges have been seen.
- R8: In lead mode (`slave_mode_i`=0) `refresh_pull_o` never rises, even when the pairs differ; a low refresh line still resets the tile.
- R9: When the two pairs are equal at a frame rising edge, `refresh_pull_o` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tile clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slave_mode_i | input | 1 | 1 = follower tile (compares), 0 = lead tile |
| local_sel_i | input | SEL_W | Locally generated row-select pair |
| master_sel_i | input | SEL_W | Row-select pair received from the lead tile |
| frame_i | input | 1 | Frame pulse, rising once per half-frame, synchronous to clk_i |
| refresh_line_ni | input | 1 | Sensed level of the shared open-drain refresh line (low = refresh) |
| refresh_pull_o | output | 1 | 1 = drive the shared refresh line low |
| tile_reset_o | output | 1 | Internal timing reset |
| display_blank_o | output | 1 | 1 = hold the display off |

## Verification
The bench aims at the following corner cases, each paired with what a faulty design would do.
- A mismatch on the very first edge after a reset, after a refresh, or after a return to follower mode. A design without the arming step would start a refresh that nothing justified.
- A difference in only the low bit or only the high bit of the pair. A design that compares only one bit would miss the slip.
- A refresh line pulled by another tile for one cycle and for several cycles. Here a design with a wrong synchroniser depth or a missing stretch would show a reset that starts or ends one cycle off.
- The eighth frame edge after recovery. A blanking counter off by one would unblank a frame early or late.

Randomised half-frames in both modes check that lead tiles stay silent. Their expected pull, reset and blank values come from a requirement-level model of arming and edge counting.

// File: rtl/scan_sync_pkg.sv
package scan_sync_pkg;

    // Registered state of the frame edge detector.
    typedef struct packed {
        logic frame_prev;
    } edge_state_t;

    // True when any bit of two row-select pairs disagrees.
    function automatic logic pairs_differ(input logic [7:0] a, input logic [7:0] b);
        return |(a ^ b);
    endfunction

endpackage

// File: rtl/scan_frame_edge.sv
module scan_frame_edge
    import scan_sync_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic frame_i,
    output logic rise_o
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.frame_prev = frame_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = frame_i & ~st_q.frame_prev;
endmodule

// File: rtl/scan_line_sync.sv
module scan_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_ni,
    output logic reset_o
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[PIPE_W-2:0], ~line_ni};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // The last synchroniser stage, widened by one extra cycle.
    assign reset_o = st_q.pipe[SYNC_STAGES-1] | st_q.pipe[SYNC_STAGES];
endmodule

// File: rtl/scan_pair_compare.sv
module scan_pair_compare
    import scan_sync_pkg::*;
#(
    parameter int SEL_W        = 2,
    parameter int DRIVE_CYCLES = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rise_i,
    input  logic             tile_reset_i,
    input  logic             slave_mode_i,
    input  logic [SEL_W-1:0] local_sel_i,
    input  logic [SEL_W-1:0] master_sel_i,
    output logic             pull_o
);
    localparam int CW = $clog2(DRIVE_CYCLES + 1);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] left;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       differs;

    always_comb begin
        differs = pairs_differ(8'(local_sel_i), 8'(master_sel_i));
        st_d    = st_q;
        if (st_q.left != '0) begin
            st_d.left = st_q.left - CW'(1);
        end
        if (tile_reset_i || !slave_mode_i) begin
            st_d.armed = 1'b0;
        end else if (rise_i) begin
            if (!st_q.armed) begin
                st_d.armed = 1'b1;
            end else if (differs && st_q.left == '0) begin
                st_d.left = CW'(DRIVE_CYCLES);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pull_o = (st_q.left != '0);
endmodule

// File: rtl/scan_blank_hold.sv
module scan_blank_hold #(
    parameter int BLANK_EDGES = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,
    input  logic tile_reset_i,
    output logic blank_o
);
    localparam int BW = $clog2(BLANK_EDGES + 1);

    typedef struct packed {
        logic [BW-1:0] edges_left;
    } blank_state_t;

    blank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tile_reset_i) begin
            st_d.edges_left = BW'(BLANK_EDGES);
        end else if (rise_i && st_q.edges_left != '0) begin
            st_d.edges_left = st_q.edges_left - BW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{edges_left: BW'(BLANK_EDGES)};
        else         st_q <= st_d;
    end

    assign blank_o = tile_reset_i | (st_q.edges_left != '0);
endmodule

// File: rtl/scan_sync_guard.sv
module scan_sync_guard #(
    parameter int SEL_W           = 2,
    parameter int DRIVE_CYCLES    = 4,
    parameter int SYNC_STAGES     = 2,
    parameter int BLANK_FRAMES    = 4,
    parameter int EDGES_PER_FRAME = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             slave_mode_i,
    input  logic [SEL_W-1:0] local_sel_i,
    input  logic [SEL_W-1:0] master_sel_i,
    input  logic             frame_i,
    input  logic             refresh_line_ni,
    output logic             refresh_pull_o,
    output logic             tile_reset_o,
    output logic             display_blank_o
);
    localparam int BLANK_EDGES = BLANK_FRAMES * EDGES_PER_FRAME;

    logic frame_rise;

    scan_frame_edge u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .frame_i (frame_i),
        .rise_o  (frame_rise)
    );

    scan_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .line_ni (refresh_line_ni),
        .reset_o (tile_reset_o)
    );

    scan_pair_compare #(.SEL_W(SEL_W), .DRIVE_CYCLES(DRIVE_CYCLES)) u_cmp (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .rise_i       (frame_rise),
        .tile_reset_i (tile_reset_o),
        .slave_mode_i (slave_mode_i),
        .local_sel_i  (local_sel_i),
        .master_sel_i (master_sel_i),
        .pull_o       (refresh_pull_o)
    );

    scan_blank_hold #(.BLANK_EDGES(BLANK_EDGES)) u_blank (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .rise_i       (frame_rise),
        .tile_reset_i (tile_reset_o),
        .blank_o      (display_blank_o)
    );
endmodule

// File: rtl/scan_sync_guard_chk.sv
module scan_sync_guard_chk #(
    parameter int SEL_W        = 2,
    parameter int DRIVE_CYCLES = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             slave_mode_i,
    input logic [SEL_W-1:0] local_sel_i,
    input logic [SEL_W-1:0] master_sel_i,
    input logic             frame_i,
    input logic             refresh_line_ni,
    input logic             refresh_pull_o,
    input logic             tile_reset_o,
    input logic             display_blank_o
);
    logic [2:0] since_rst_q;
    logic [3:0] run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_rst_q <= '0;
            run_q       <= '0;
        end else begin
            if (since_rst_q != 3'd7) since_rst_q <= since_rst_q + 3'd1;
            if (!refresh_pull_o)     run_q <= '0;
            else if (run_q != 4'hF)  run_q <= run_q + 4'd1;
        end
    end

    // R4: each pull burst lasts exactly DRIVE_CYCLES
    assert_pull_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(refresh_pull_o) |-> (run_q == 4'(DRIVE_CYCLES)));

    assert_pull_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q <= 4'(DRIVE_CYCLES));

    // R2, R8: a pull starts only after a differing follower-mode edge outside reset
    assert_pull_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst_q >= 3'd3) && $rose(refresh_pull_o) |->
            $past(slave_mode_i) && $past(local_sel_i != master_sel_i) &&
            $past(frame_i) && !$past(frame_i, 2) && !$past(tile_reset_o));

    // R5: a sensed low line resets the tile two edges later
    assert_line_resets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst_q >= 3'd3) && !$past(refresh_line_ni, 2) |-> tile_reset_o);

    // R6: reset ends one cycle after the synchronised line returns high
    assert_reset_stretch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst_q >= 3'd5) && $fell(tile_reset_o) |->
            $past(refresh_line_ni, 2) && $past(refresh_line_ni, 3) && !$past(refresh_line_ni, 4));

    // R7: blanking continues after the tile reset is released
    assert_blank_after_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(tile_reset_o) |-> display_blank_o);
endmodule

bind scan_sync_guard scan_sync_guard_chk #(.SEL_W(SEL_W), .DRIVE_CYCLES(DRIVE_CYCLES)) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .slave_mode_i    (slave_mode_i),
    .local_sel_i     (local_sel_i),
    .master_sel_i    (master_sel_i),
    .frame_i         (frame_i),
    .refresh_line_ni (refresh_line_ni),
    .refresh_pull_o  (refresh_pull_o),
    .tile_reset_o    (tile_reset_o),
    .display_blank_o (display_blank_o)
);

// File: tb/tb_scan_sync_guard.sv
module tb_scan_sync_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slave_mode = 1'b1;
    logic [1:0] loc_sel = '0;
    logic [1:0] mst_sel = '0;
    logic       frame = 1'b0;
    logic       ext_pull = 1'b0;
    logic       line_n;
    logic       pull, treset, blank;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit armed_exp = 0;
    int blank_left = 8;

    always #4 clk = ~clk;

    // Wired-OR of this tile's pull and any other tile's pull.
    assign line_n = ~(pull | ext_pull);

    scan_sync_guard dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .slave_mode_i    (slave_mode),
        .local_sel_i     (loc_sel),
        .master_sel_i    (mst_sel),
        .frame_i         (frame),
        .refresh_line_ni (line_n),
        .refresh_pull_o  (pull),
        .tile_reset_o    (treset),
        .display_blank_o (blank)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit expect_pull(input bit slv, input bit armed, input logic [1:0] a, input logic [1:0] b);
        return slv && armed && (a != b);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        frame = 1'b0;
        ext_pull = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pull", pull, 0);
        check("R1 reset", treset, 0);
        check("R1 blank", blank, 1);
        armed_exp = 0;
        blank_left = 8;
    endtask

    // One half-frame: 20 cycles, frame high for the first 3.
    task automatic half_frame(input bit slv, input logic [1:0] a, input logic [1:0] b);
        bit ep;
        ep = expect_pull(slv, armed_exp, a, b);
        slave_mode = slv;
        loc_sel = a;
        mst_sel = b;
        frame = 1'b1;
        if (blank_left > 0) blank_left--;
        if (!slv || ep) armed_exp = 0;
        else            armed_exp = 1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 1) begin
                check(slv ? (a == b ? "R9 pull" : "R2/R3 pull") : "R8 pull", pull, ep);
                check("R7 blank count", blank, (blank_left != 0) ? 1 : 0);
            end
            if (k == 3) check("R5 reset start", treset, ep);
            if (k == 4) check("R4 pull held", pull, ep);
            if (k == 5) check("R4 pull released", pull, 0);
            if (k == 7) check("R6 reset held", treset, ep);
            if (k == 8) begin
                check("R6 reset end", treset, 0);
                if (ep) check("R7 blank after reset", blank, 1);
            end
            if (k == 3) frame = 1'b0;
        end
        if (ep) blank_left = 8;
    endtask

    // Another tile pulls the line for len cycles.
    task automatic ext_refresh(input int len);
        @(negedge clk);
        ext_pull = 1'b1;
        for (int k = 1; k <= len + 4; k++) begin
            @(negedge clk);
            if (k == 1)       check("R5 not yet", treset, 0);
            if (k == 2)       check("R5 ext reset", treset, 1);
            if (k == len + 2) check("R6 ext stretch", treset, 1);
            if (k == len + 3) begin
                check("R6 ext end", treset, 0);
                check("R7 ext blank", blank, 1);
                check("R8 no own pull", pull, 0);
            end
            if (k == len) ext_pull = 1'b0;
        end
        armed_exp = 0;
        blank_left = 8;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        do_reset();
        // R3: mismatch on the first edge only arms
        half_frame(1, 2'd2, 2'd1);
        // R7: blank releases on the eighth edge
        for (int i = 0; i < 7; i++) half_frame(1, 2'(i), 2'(i));
        // R2: low-bit difference
        half_frame(1, 2'd0, 2'd1);
        // R3: first edge after a tile reset
        half_frame(1, 2'd3, 2'd2);
        // R2: high-bit difference
        half_frame(1, 2'd1, 2'd3);
        // R8: lead mode stays silent
        for (int i = 0; i < 3; i++) half_frame(0, 2'd0, 2'd3);
        // R3: re-entering follower mode
        half_frame(1, 2'd0, 2'd3);
        half_frame(1, 2'd0, 2'd3);
        // R5/R6: refresh from another tile
        ext_refresh(6);
        ext_refresh(1);
        half_frame(0, 2'd1, 2'd2);
        ext_refresh(3);
        // Random mix
        for (int i = 0; i < 120; i++) begin
            int r;
            logic [1:0] a, b;
            bit slv;
            r = int'($urandom_range(0, 99));
            slv = (r >= 15);
            a = 2'($urandom_range(0, 3));
            b = (int'($urandom_range(0, 99)) < 30) ? 2'($urandom_range(0, 3)) : a;
            if (r < 5) ext_refresh(int'($urandom_range(1, 8)));
            half_frame(slv, a, b);
        end
        // R1/R3: second power-on reset
        do_reset();
        half_frame(1, 2'd1, 2'd2);
        half_frame(1, 2'd1, 2'd2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule